// File: doc/BRIEF.md
# FIFO Threshold DMA Request Generator

This block turns the byte occupancy of a serial port's transmit and receive FIFOs into two threshold flags and two DMA request lines. Each byte count is first converted into a count of samples, using the configured sample width of one to four bytes. The transmit side asks for more data when its sample count is at or below its threshold. The receive side asks to be drained when its sample count is at or above its threshold. In the SPI frame format the receive condition is always true.

Each request line has a level handshake with an external DMA controller. A request goes high once its DMA enable is set and the condition holds. It then stays high until the controller raises the matching acknowledge. While the acknowledge is high the request stays low. After the acknowledge falls, the request comes back only if the condition still holds. When the port enable is low, all flags and requests keep their current values. Every output is registered, so a change at the inputs appears one cycle later.

Top module: `ssp_dma_req_gen`

## Requirements
- R1: During synchronous reset (rst_n low) both request lines and rx_flag are low and tx_flag is high, from the first clock edge of the reset onwards.
- R2: A FIFO level in samples is the byte count divided by the sample size with truncation. The sample size in bytes is width_sel+1 (width_sel 0 = 1 byte, 1 = 2, 2 = 3, 3 = 4).
- R3: With port_en high, tx_flag on the next cycle is 1 when the TX level in samples is at or below tx_thresh, and 0 otherwise.
- R4: With port_en high and spi_fmt low, rx_flag on the next cycle is 1 when the RX level in samples is at or above rx_thresh, and 0 otherwise.
- R5: With port_en high and spi_fmt high, the RX condition holds whatever the RX level and threshold are. rx_flag is 1 on the next cycle.
- R6: With port_en and the DMA enable of a direction high, its acknowledge low and its condition true, its request is high on the next cycle. A request that is already high stays high after the condition goes false, as long as no acknowledge arrives.
- R7: With port_en and the DMA enable high, a high acknowledge makes the matching request low on the next cycle, even when the condition holds in that cycle.
- R8: After the acknowledge falls, the request rises on the next cycle only if the condition holds. Otherwise it stays low until the condition becomes true.
- R9: With a direction's DMA enable low, its request does not rise and its acknowledge has no effect: the request keeps its value.
- R10: While port_en is low, tx_flag, rx_flag, tx_req and rx_req keep their values, whatever the levels, thresholds, enables and acknowledges do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| port_en | input | 1 | Global port enable; while low, all outputs hold |
| spi_fmt | input | 1 | High when the frame format is SPI (RX condition forced true) |
| width_sel | input | 2 | Sample size minus one, in bytes |
| tx_level | input | LVL_W | TX FIFO occupancy in bytes |
| rx_level | input | LVL_W | RX FIFO occupancy in bytes |
| tx_thresh | input | THR_W | TX threshold in samples |
| rx_thresh | input | THR_W | RX threshold in samples |
| tx_dma_en | input | 1 | TX DMA request enable |
| rx_dma_en | input | 1 | RX DMA request enable |
| tx_ack | input | 1 | TX acknowledge from the DMA controller |
| rx_ack | input | 1 | RX acknowledge from the DMA controller |
| tx_req | output | 1 | TX DMA request |
| rx_req | output | 1 | RX DMA request |
| tx_flag | output | 1 | TX threshold flag |
| rx_flag | output | 1 | RX threshold flag |

## Verification
A request can be raised by its threshold condition and dropped by its acknowledge in the same cycle. The acknowledge must win. The bench provokes this by holding a direction's condition true, with its DMA enable set, while it pulses the acknowledge. It also does so in SPI format, where the RX condition is always true. On every cycle a behavioural model predicts the request. The bench then checks that the request is low one cycle after the acknowledge is sampled high, and that it comes back one cycle after the acknowledge falls, if the condition still holds.

// File: rtl/ssp_dma_req_pkg.sv
package ssp_dma_req_pkg;
    typedef struct packed {
        logic req;
        logic flag;
    } dir_state_t;
endpackage

// File: rtl/ssp_dreq_level_scale.sv
module ssp_dreq_level_scale #(
    parameter int LVL_W = 7
) (
    input  logic [LVL_W-1:0] bytes_in,
    input  logic [1:0]       width_sel,
    output logic [LVL_W-1:0] samples_out
);
    always_comb begin
        case (width_sel)
            2'd0:    samples_out = bytes_in;
            2'd1:    samples_out = bytes_in >> 1;
            2'd2:    samples_out = bytes_in / LVL_W'(3);
            default: samples_out = bytes_in >> 2;
        endcase
    end
endmodule

// File: rtl/ssp_dreq_dir.sv
module ssp_dreq_dir
    import ssp_dma_req_pkg::*;
#(
    parameter int   LVL_W    = 7,
    parameter int   THR_W    = 5,
    parameter bit   AT_LEAST = 1'b0,
    parameter logic FLAG_RST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             force_cond,
    input  logic [LVL_W-1:0] samples,
    input  logic [THR_W-1:0] thresh,
    input  logic             dma_en,
    input  logic             ack,
    output logic             req,
    output logic             flag
);
    localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

    logic [CMP_W-1:0] lvl_ext;
    logic [CMP_W-1:0] thr_ext;
    logic             cmp_hit;
    logic             cond;
    dir_state_t       st_d, st_q;

    assign lvl_ext = CMP_W'(samples);
    assign thr_ext = CMP_W'(thresh);

    generate
        if (AT_LEAST) begin : g_ge
            assign cmp_hit = (lvl_ext >= thr_ext);
        end else begin : g_le
            assign cmp_hit = (lvl_ext <= thr_ext);
        end
    endgenerate

    assign cond = force_cond | cmp_hit;

    always_comb begin
        st_d = st_q;
        if (port_en) begin
            st_d.flag = cond;
            if (dma_en) begin
                if (ack) begin
                    st_d.req = 1'b0;
                end else if (cond) begin
                    st_d.req = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.req  <= 1'b0;
            st_q.flag <= FLAG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign req  = st_q.req;
    assign flag = st_q.flag;
endmodule

// File: rtl/ssp_dma_req_gen.sv
module ssp_dma_req_gen #(
    parameter int LVL_W = 7,
    parameter int THR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             spi_fmt,
    input  logic [1:0]       width_sel,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] tx_thresh,
    input  logic [THR_W-1:0] rx_thresh,
    input  logic             tx_dma_en,
    input  logic             rx_dma_en,
    input  logic             tx_ack,
    input  logic             rx_ack,
    output logic             tx_req,
    output logic             rx_req,
    output logic             tx_flag,
    output logic             rx_flag
);
    logic [LVL_W-1:0] tx_samples;
    logic [LVL_W-1:0] rx_samples;

    ssp_dreq_level_scale #(.LVL_W(LVL_W)) u_tx_scale (
        .bytes_in    (tx_level),
        .width_sel   (width_sel),
        .samples_out (tx_samples)
    );

    ssp_dreq_level_scale #(.LVL_W(LVL_W)) u_rx_scale (
        .bytes_in    (rx_level),
        .width_sel   (width_sel),
        .samples_out (rx_samples)
    );

    ssp_dreq_dir #(
        .LVL_W(LVL_W), .THR_W(THR_W), .AT_LEAST(1'b0), .FLAG_RST(1'b1)
    ) u_tx_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_en    (port_en),
        .force_cond (1'b0),
        .samples    (tx_samples),
        .thresh     (tx_thresh),
        .dma_en     (tx_dma_en),
        .ack        (tx_ack),
        .req        (tx_req),
        .flag       (tx_flag)
    );

    ssp_dreq_dir #(
        .LVL_W(LVL_W), .THR_W(THR_W), .AT_LEAST(1'b1), .FLAG_RST(1'b0)
    ) u_rx_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_en    (port_en),
        .force_cond (spi_fmt),
        .samples    (rx_samples),
        .thresh     (rx_thresh),
        .dma_en     (rx_dma_en),
        .ack        (rx_ack),
        .req        (rx_req),
        .flag       (rx_flag)
    );
endmodule

// File: rtl/ssp_dma_req_gen_chk.sv
module ssp_dma_req_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic spi_fmt,
    input logic tx_dma_en,
    input logic rx_dma_en,
    input logic tx_ack,
    input logic rx_ack,
    input logic tx_req,
    input logic rx_req,
    input logic tx_flag,
    input logic rx_flag
);
    // R7: a sampled acknowledge drops the request, whatever the condition
    assert_tx_ack_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && tx_dma_en && tx_ack) |=> !tx_req);
    assert_rx_ack_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && rx_dma_en && rx_ack) |=> !rx_req);

    // R10: outputs frozen while the port is disabled
    assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> ($stable(tx_req) && $stable(rx_req) && $stable(tx_flag) && $stable(rx_flag)));

    // R6 / R9: a request only rises after an enabled, unacknowledged cycle
    assert_tx_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> $past(port_en && tx_dma_en && !tx_ack));
    assert_rx_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_req) |-> $past(port_en && rx_dma_en && !rx_ack));

    // R5: SPI format forces the receive flag
    assert_spi_rx_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && spi_fmt) |=> rx_flag);

    // R5: in SPI format an enabled, unacknowledged RX request is raised
    assert_spi_rx_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && spi_fmt && rx_dma_en && !rx_ack) |=> rx_req);
endmodule

bind ssp_dma_req_gen ssp_dma_req_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_en   (port_en),
    .spi_fmt   (spi_fmt),
    .tx_dma_en (tx_dma_en),
    .rx_dma_en (rx_dma_en),
    .tx_ack    (tx_ack),
    .rx_ack    (rx_ack),
    .tx_req    (tx_req),
    .rx_req    (rx_req),
    .tx_flag   (tx_flag),
    .rx_flag   (rx_flag)
);

// File: tb/ssp_dma_req_gen_tb_top.sv
module ssp_dma_req_gen_tb_top;
    localparam int LVL_W = 7;
    localparam int THR_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             port_en = 1'b0;
    logic             spi_fmt = 1'b0;
    logic [1:0]       width_sel = 2'd0;
    logic [LVL_W-1:0] tx_level = '0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [THR_W-1:0] tx_thresh = 5'd4;
    logic [THR_W-1:0] rx_thresh = 5'd4;
    logic             tx_dma_en = 1'b0;
    logic             rx_dma_en = 1'b0;
    logic             tx_ack = 1'b0;
    logic             rx_ack = 1'b0;
    logic             tx_req, rx_req, tx_flag, rx_flag;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // behavioural reference state
    int e_txf = 1, e_rxf = 0, e_txr = 0, e_rxr = 0;

    always #5 clk = ~clk;

    ssp_dma_req_gen #(.LVL_W(LVL_W), .THR_W(THR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .spi_fmt(spi_fmt),
        .width_sel(width_sel), .tx_level(tx_level), .rx_level(rx_level),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
        .tx_ack(tx_ack), .rx_ack(rx_ack),
        .tx_req(tx_req), .rx_req(rx_req), .tx_flag(tx_flag), .rx_flag(rx_flag)
    );

    task automatic model_step();
        int ts, rs, tc, rc;
        if (!rst_n) begin
            e_txf = 1; e_rxf = 0; e_txr = 0; e_rxr = 0;
        end else if (port_en) begin
            ts = int'(tx_level) / (int'(width_sel) + 1);
            rs = int'(rx_level) / (int'(width_sel) + 1);
            tc = (ts <= int'(tx_thresh)) ? 1 : 0;
            rc = (spi_fmt || rs >= int'(rx_thresh)) ? 1 : 0;
            e_txf = tc;
            e_rxf = rc;
            if (tx_dma_en) e_txr = tx_ack ? 0 : (tc ? 1 : e_txr);
            if (rx_dma_en) e_rxr = rx_ack ? 0 : (rc ? 1 : e_rxr);
        end
    endtask

    task automatic cmp(string name, logic act, int exp);
        n_checks++;
        if (act !== 1'(exp)) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%0d t=%0t", cur_req, name, act, exp, $time);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            cmp("tx_flag", tx_flag, e_txf);
            cmp("rx_flag", rx_flag, e_rxf);
            cmp("tx_req",  tx_req,  e_txr);
            cmp("rx_req",  rx_req,  e_rxr);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        run(3);
        rst_n = 1'b1;
        port_en = 1'b1;

        // R2, R3: TX level conversion and threshold at every sample size
        cur_req = "R2_R3";
        tx_thresh = 5'd4;
        width_sel = 2'd3; tx_level = 7'd19; run(2);   // 4 samples -> flag 1
        tx_level = 7'd20; run(2);                     // 5 samples -> flag 0
        width_sel = 2'd2; tx_level = 7'd14; run(2);   // 4 samples
        tx_level = 7'd15; run(2);                     // 5 samples
        width_sel = 2'd1; tx_level = 7'd9;  run(2);
        width_sel = 2'd0; tx_level = 7'd5;  run(2);
        tx_thresh = 5'd0; tx_level = 7'd0;  run(2);

        // R4: RX threshold at or above
        cur_req = "R4";
        rx_thresh = 5'd3; width_sel = 2'd1;
        rx_level = 7'd5; run(2);                      // 2 samples -> 0
        rx_level = 7'd6; run(2);                      // 3 samples -> 1
        rx_thresh = 5'd31; rx_level = 7'd127; run(2); // 63 samples -> 1
        rx_level = 7'd0; rx_thresh = 5'd0; run(2);    // 0 >= 0 -> 1
        rx_thresh = 5'd1; run(2);

        // R5: SPI forces RX condition
        cur_req = "R5";
        spi_fmt = 1'b1; rx_level = 7'd0; rx_thresh = 5'd20; run(3);
        rx_dma_en = 1'b1; run(2);
        rx_ack = 1'b1; run(2);                        // ack beats forced condition
        rx_ack = 1'b0; run(2);
        spi_fmt = 1'b0; rx_dma_en = 1'b0; run(2);

        // R6: raise and sticky hold
        cur_req = "R6";
        tx_thresh = 5'd4; width_sel = 2'd0; tx_level = 7'd2;
        tx_dma_en = 1'b1; run(2);
        tx_level = 7'd30; run(3);                     // condition false, req stays

        // R7: acknowledge wins over a true condition
        cur_req = "R7";
        tx_level = 7'd1; tx_ack = 1'b1; run(3);
        // R8: re-raise only when the condition holds
        cur_req = "R8";
        tx_ack = 1'b0; run(2);
        tx_ack = 1'b1; run(1);
        tx_level = 7'd30; tx_ack = 1'b0; run(3);      // stays low
        tx_level = 7'd3; run(2);                      // rises again

        // R9: DMA disabled
        cur_req = "R9";
        tx_dma_en = 1'b0; tx_ack = 1'b1; run(2);      // req holds high
        tx_ack = 1'b0; rx_dma_en = 1'b0; rx_level = 7'd100; rx_thresh = 5'd1; run(2);

        // R10: port disabled holds everything
        cur_req = "R10";
        port_en = 1'b0;
        tx_dma_en = 1'b1; tx_ack = 1'b1; tx_level = 7'd100; rx_level = 7'd0;
        rx_dma_en = 1'b1; spi_fmt = 1'b1; run(4);
        port_en = 1'b1; run(2);
        tx_ack = 1'b0; spi_fmt = 1'b0;

        // mixed patterns covering R3 R4 R6 R7 R8 R9 R10 together
        cur_req = "R3_R4_R6_R7_R8_R9_R10";
        for (int k = 0; k < 400; k++) begin
            port_en   = ($urandom % 8) != 0;
            spi_fmt   = ($urandom % 6) == 0;
            width_sel = 2'($urandom);
            tx_level  = 7'($urandom);
            rx_level  = 7'($urandom);
            tx_thresh = 5'($urandom);
            rx_thresh = 5'($urandom);
            tx_dma_en = ($urandom % 5) != 0;
            rx_dma_en = ($urandom % 5) != 0;
            tx_ack    = ($urandom % 3) == 0;
            rx_ack    = ($urandom % 3) == 0;
            run(1);
        end

        // R1: reset again from an active state
        cur_req = "R1";
        rst_n = 1'b0; run(2);
        finish_run();
    end
endmodule